// File: doc/BRIEF.md
# Decimal Digit Adder with Six-Correction

This block adds two packed decimal digits, each held in four bits, together with a single carry bit. It returns one decimal result digit and a decimal carry. The result comes from two steps. A plain 4-bit binary addition forms a 5-bit intermediate value. A detection term then checks whether that value has left the decimal range. When it has, the block adds six to the low four bits, which folds the result back into a valid digit and raises the carry.

The block is purely combinational. The carry output is meant to feed the carry input of the next more significant digit, so a row of these cells forms a multi-digit decimal adder. The block also raises a flag when either operand holds one of the six codes above nine. In that case it still computes its outputs by the same fixed rule, so downstream logic sees a predictable value.

Top module: `bcd_digit_adder`

## Requirements
- R1: When both operands are 0..9 and opA+opB+carryIn is 0..9, sumDigit equals that total and carryOut is 0.
- R2: When both operands are 0..9 and the total is 10..15, the intermediate binary value 1010..1111 triggers correction: sumDigit equals total minus 10 and carryOut is 1.
- R3: When both operands are 0..9 and the total is 16..19, the intermediate binary carry triggers correction: sumDigit equals total minus 10 and carryOut is 1.
- R4: For operands in 0..9, sumDigit never exceeds 9 and carryOut*10 + sumDigit equals opA+opB+carryIn.
- R5: badDigit is 1 exactly when opA or opB holds a code 10..15 (binary 1010..1111), and is 0 otherwise.
- R6: With an illegal operand, the outputs follow the same rule. Let S be the 5-bit binary sum. Correction is on when S bit 4 is set, or when S bit 3 is set together with bit 2 or bit 1. sumDigit is then the low four bits of S[3:0]+6, and carryOut equals the correction term.
- R7: Two cells with the low cell's carryOut wired to the high cell's carryIn produce the correct two-digit decimal sum and final carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | First decimal operand digit |
| opB | input | 4 | Second decimal operand digit |
| carryIn | input | 1 | Decimal carry from the less significant digit |
| sumDigit | output | 4 | Decimal result digit |
| carryOut | output | 1 | Decimal carry to the more significant digit |
| badDigit | output | 1 | Either operand is above nine |

## Verification
The hardest case to reach is the corner where the binary carry and the range-detect term disagree. Totals of 16 to 19 have low bits 0000 to 0011. There only the intermediate carry can trigger correction, while the S bit 3 term stays silent. The stimulus sweeps every operand code 0..15 against every other code with both carry values. This reaches all four of those totals, the 1010..1111 window and the illegal-code wraparound, such as 15+15+1. A second cell chained on the carry checks that the carry arrives correctly in a two-digit sum.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  parameter int DIGIT_W = 4;
  localparam int RADIX = 10;
  localparam int MAX_DIGIT = RADIX - 1;
  localparam logic [DIGIT_W-1:0] FIX_ADD = DIGIT_W'((2 ** DIGIT_W) - RADIX);
  localparam logic [DIGIT_W-1:0] DIGIT_LIMIT = DIGIT_W'(MAX_DIGIT);

  typedef struct packed {
    logic fixEn;
    logic [DIGIT_W-1:0] fixAddend;
  } fixStrobes_t;
endpackage

// File: rtl/bcd_add_control.sv
module bcd_add_control
  import bcd_add_pkg::*;
(
  input  logic [DIGIT_W:1]   detectBits,
  input  logic [DIGIT_W-1:0] opA,
  input  logic [DIGIT_W-1:0] opB,
  output fixStrobes_t        strobes,
  output logic               badDigit
);
  logic rangeHit;
  logic needFix;

  // Intermediate 1010..1111: top bit set with either of the two next bits.
  always_comb begin
    rangeHit = detectBits[DIGIT_W-1] & (detectBits[DIGIT_W-2] | detectBits[DIGIT_W-3]);
    needFix = detectBits[DIGIT_W] | rangeHit;
    strobes.fixEn = needFix;
    strobes.fixAddend = needFix ? FIX_ADD : '0;
    badDigit = (opA > DIGIT_LIMIT) | (opB > DIGIT_LIMIT);
  end
endmodule

// File: rtl/bcd_add_datapath.sv
module bcd_add_datapath
  import bcd_add_pkg::*;
(
  input  logic [DIGIT_W-1:0] opA,
  input  logic [DIGIT_W-1:0] opB,
  input  logic               carryIn,
  input  fixStrobes_t        strobes,
  output logic [DIGIT_W:0]   rawSum,
  output logic [DIGIT_W-1:0] sumDigit,
  output logic               carryOut
);
  always_comb begin
    rawSum = {1'b0, opA} + {1'b0, opB} + {{DIGIT_W{1'b0}}, carryIn};
  end

  // The six-adder keeps only the low bits; its own carry is not used.
  always_comb begin
    sumDigit = rawSum[DIGIT_W-1:0] + strobes.fixAddend;
    carryOut = strobes.fixEn;
  end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_add_pkg::*;
(
  input  logic [3:0] opA,
  input  logic [3:0] opB,
  input  logic       carryIn,
  output logic [3:0] sumDigit,
  output logic       carryOut,
  output logic       badDigit
);
  logic [DIGIT_W:0] rawSum;
  fixStrobes_t strobes;

  bcd_add_datapath i_datapath (
    .opA(opA), .opB(opB), .carryIn(carryIn), .strobes(strobes),
    .rawSum(rawSum), .sumDigit(sumDigit), .carryOut(carryOut)
  );

  bcd_add_control i_control (
    .detectBits(rawSum[DIGIT_W:1]), .opA(opA), .opB(opB),
    .strobes(strobes), .badDigit(badDigit)
  );
endmodule

// File: rtl/bcd_digit_adder_chk.sv
module bcd_digit_adder_chk (
  input logic [3:0] opA,
  input logic [3:0] opB,
  input logic       carryIn,
  input logic [3:0] sumDigit,
  input logic       carryOut,
  input logic       badDigit
);
  logic legalOps;
  logic [4:0] total;

  always_comb begin
    legalOps = (opA <= 4'd9) && (opB <= 4'd9);
    total = 5'(opA) + 5'(opB) + 5'(carryIn);
    if (legalOps && total < 5'd10) AST_SMALL_PASS: assert (!carryOut && sumDigit == total[3:0]); // R1
    if (legalOps) AST_DIGIT_RANGE: assert (sumDigit <= 4'd9); // R4
    if (legalOps) AST_VALUE_KEPT: assert ((carryOut ? 5'd10 : 5'd0) + 5'(sumDigit) == total); // R4
    if (total >= 5'd10) AST_CARRY_RAISED: assert (carryOut); // R3
    if (legalOps) AST_NO_FLAG: assert (!badDigit); // R5
    if (!legalOps) AST_FLAG_SET: assert (badDigit); // R5
  end
endmodule

bind bcd_digit_adder bcd_digit_adder_chk i_chk (.*);

// File: tb/test_bcd_digit_adder.sv
module test_bcd_digit_adder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] opA = '0, opB = '0, hiA = '0, hiB = '0;
  logic carryIn = 1'b0;
  logic [3:0] sumDigit, hiDigit;
  logic carryOut, badDigit, hiCarry, hiBad;

  bcd_digit_adder i_bcd_digit_adder (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumDigit(sumDigit), .carryOut(carryOut), .badDigit(badDigit)
  );

  bcd_digit_adder i_bcd_digit_adder_hi (
    .opA(hiA), .opB(hiB), .carryIn(carryOut),
    .sumDigit(hiDigit), .carryOut(hiCarry), .badDigit(hiBad)
  );

  typedef struct {
    int tot;
    bit legal;
    int dig;
    int co;
    int hDig;
    int hCo;
  } expItem_t;

  expItem_t sbQ[$];
  int compared = 0;
  int mismatched = 0;
  bit driveDone = 0;

  task automatic check(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(int a, int b, int cin);
    expItem_t e;
    int bin, c, corr, hA, hB, hTot;
    e.tot = a + b + cin;
    e.legal = (a <= 9) && (b <= 9);
    if (e.legal) begin
      e.dig = e.tot % 10;
      e.co = (e.tot >= 10) ? 1 : 0;
    end else begin
      bin = e.tot & 15;
      c = (e.tot >> 4) & 1;
      corr = c | (((bin >> 3) & 1) & (((bin >> 2) & 1) | ((bin >> 1) & 1)));
      e.dig = (bin + (corr != 0 ? 6 : 0)) & 15;
      e.co = corr;
    end
    hA = (a * 3 + 1) % 10;
    hB = (b + cin * 5) % 10;
    hTot = hA + hB + e.co;
    e.hDig = hTot % 10;
    e.hCo = (hTot >= 10) ? 1 : 0;
    @(posedge clk);
    opA = 4'(a);
    opB = 4'(b);
    carryIn = cin[0];
    hiA = 4'(hA);
    hiB = 4'(hB);
    sbQ.push_back(e);
  endtask

  always @(negedge clk) begin
    expItem_t e;
    string tag;
    if (rstN && sbQ.size() > 0) begin
      e = sbQ.pop_front();
      if (!e.legal) tag = "R6";
      else if (e.tot < 10) tag = "R1";
      else if (e.tot < 16) tag = "R2";
      else tag = "R3";
      check({tag, " digit"}, int'(sumDigit), e.dig);
      check({tag, " carry"}, int'(carryOut), e.co);
      check("R5 flag", int'(badDigit), e.legal ? 0 : 1);
      if (e.legal) check("R4 range", (sumDigit <= 4'd9) ? 1 : 0, 1);
      check("R7 high digit", int'(hiDigit), e.hDig);
      check("R7 high carry", int'(hiCarry), e.hCo);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 idle digit", int'(sumDigit), 0);
    check("R1 idle carry", int'(carryOut), 0);
    check("R5 idle flag", int'(badDigit), 0);
    rstN = 1'b1;
    for (int cin = 0; cin < 2; cin++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(a, b, cin);
    repeat (4) @(posedge clk);
    driveDone = 1;
  end

  initial begin
    fork
      wait (driveDone);
      begin
        repeat (5000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule